// File: doc/BRIEF.md
# Character-Addressed Hi-Res Overlay Memory

This block holds a bit-mapped overlay of 384 x 192 dots that sits beside a text-mode video path. The overlay is stored as 12288 six-bit cells. One cell is one raster line of one 6-dot character position. A processor writes and reads the cells through a 16-bit address. That address is not a linear offset: it packs the character column, the character row and the raster line inside the character cell into separate fields.

On the video side, a request names a row, a column and a raster line, together with the 6 text dots for that spot. One cycle later the block returns the text dots, ORed with the stored overlay dots when the overlay is switched on. It then shifts the same six dots out serially, least-significant bit first.

Processor reads always return the raw overlay contents, never the merged image. A single enable register decides whether the overlay takes part in the video output at all.

Top module: `hires_overlay`

## Requirements
- R1: The processor address is decoded as column = addr[5:0], row = addr[9:6] and raster line = addr[13:10]. A cell written through the processor port is the cell that the video port reads with the same row, column and line. Address bits [15:14] are ignored, so an address differing only in those bits reaches the same cell.
- R2: When cpu_we_i is high, cpu_wdata_i is stored in the addressed cell at that clock edge. When cpu_re_i is high, cpu_rdata_o shows the addressed cell's contents after the next clock edge. While cpu_re_i is low, cpu_rdata_o holds its value.
- R3: A raster-line field of 12 to 15 addresses no cell. A write to it changes no cell, and a read of it returns 0.
- R4: Processor reads return the stored overlay value. That value does not depend on the enable register or on the video text dots.
- R5: en_we_i loads en_wdata_i into the enable register, and the new value is visible on en_o after the next edge. While en_we_i is low, en_o holds its value.
- R6: One edge after vid_req_i, vid_dots_o carries the overlay cell ORed with vid_text_i when en_o is 1, and carries vid_text_i alone when en_o is 0. A video line of 12 to 15 yields vid_text_i alone.
- R7: The serial output vid_dot_o carries bit k of vid_dots_o in the cycle k+2 after the request cycle, for k = 0 to 5, so bit 0 comes first. In the cycle after the sixth dot, vid_dot_o is 0.
- R8: When a processor write and a video read hit the same cell in the same cycle, the video read returns the old contents. A processor write with a simultaneous processor read of the same address also returns the old contents.
- R9: During reset, cpu_rdata_o, vid_dots_o, vid_dot_o and en_o are all 0. The overlay cells themselves are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_we_i | input | 1 | Processor write strobe |
| cpu_re_i | input | 1 | Processor read strobe |
| cpu_addr_i | input | 16 | Packed address: line, row and column fields |
| cpu_wdata_i | input | 6 | Cell write data |
| cpu_rdata_o | output | 6 | Raw cell read data, one cycle latency |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 1 | New enable value |
| en_o | output | 1 | Current enable state |
| vid_req_i | input | 1 | Video cell request |
| vid_row_i | input | 4 | Video character row |
| vid_col_i | input | 6 | Video character column |
| vid_line_i | input | 4 | Video raster line in the cell |
| vid_text_i | input | 6 | Text dots for the requested spot |
| vid_dots_o | output | 6 | Merged dots, bit 0 is shown first |
| vid_dot_o | output | 1 | Serial dot stream, LSB first |

## Verification
Suppose the address fields are swapped or the bank select is wrong. A cell written through the processor port then shows up at another row, column or line when the video port fetches it, and the wrong dots appear in vid_dots_o one cycle after the request. A broken invalid-line guard shows up either as a nonzero read of lines 12 to 15, or as a corrupted neighbouring cell on a later read-back. A wrong enable state or a wrong merge term shows in the very next vid_dots_o. A reversed or mistimed shifter shows within the six dot cycles after that.

// File: rtl/hro_pkg.sv
package hro_pkg;
  // address layout is behaviour: column low, row middle, raster line above
  localparam int unsigned HRO_ADDR_W = 16;
  localparam int unsigned HRO_COL_W  = 6;
  localparam int unsigned HRO_ROW_W  = 4;
  localparam int unsigned HRO_LINE_W = 4;
  localparam int unsigned HRO_IDX_W  = HRO_COL_W + HRO_ROW_W;
  localparam int unsigned HRO_USED_W = HRO_IDX_W + HRO_LINE_W;

  typedef struct packed {
    logic [HRO_LINE_W-1:0] line;
    logic [HRO_ROW_W-1:0]  row;
    logic [HRO_COL_W-1:0]  col;
  } hro_addr_t;
endpackage

// File: rtl/hro_addr_dec.sv
module hro_addr_dec
  import hro_pkg::*;
#(
  parameter int unsigned LINES = 12
) (
  input  logic [HRO_ADDR_W-1:0] addr_i,
  output logic [HRO_LINE_W-1:0] line_o,
  output logic [HRO_IDX_W-1:0]  idx_o,
  output logic                  valid_o
);
  hro_addr_t fld;
  logic      unused_hi;

  assign fld       = hro_addr_t'(addr_i[HRO_USED_W-1:0]);
  assign unused_hi = ^addr_i[HRO_ADDR_W-1:HRO_USED_W];
  assign line_o    = fld.line;
  assign idx_o     = {fld.row, fld.col};
  assign valid_o   = (32'(fld.line) < LINES);
endmodule

// File: rtl/hro_bank.sv
module hro_bank
  import hro_pkg::*;
#(
  parameter int unsigned CELL_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [HRO_IDX_W-1:0] cpu_idx_i,
  input  logic [CELL_W-1:0]    wdata_i,
  input  logic                 cpu_re_i,
  output logic [CELL_W-1:0]    cpu_q_o,
  input  logic                 vid_re_i,
  input  logic [HRO_IDX_W-1:0] vid_idx_i,
  output logic [CELL_W-1:0]    vid_q_o
);
  localparam int unsigned DEPTH = 1 << HRO_IDX_W;

  logic [CELL_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[cpu_idx_i] <= wdata_i;
  end

  // both reads see contents from before this edge's write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_q_o <= '0;
      vid_q_o <= '0;
    end else begin
      if (cpu_re_i) cpu_q_o <= mem[cpu_idx_i];
      if (vid_re_i) vid_q_o <= mem[vid_idx_i];
    end
  end
endmodule

// File: rtl/hro_shift.sv
module hro_shift #(
  parameter int unsigned CELL_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CELL_W-1:0] data_i,
  output logic              dot_o
);
  logic [CELL_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= data_i;
    else             sr_q <= sr_q >> 1;
  end

  assign dot_o = sr_q[0];
endmodule

// File: rtl/hires_overlay.sv
module hires_overlay
  import hro_pkg::*;
#(
  parameter int unsigned CELL_W = 6,
  parameter int unsigned LINES  = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cpu_we_i,
  input  logic                  cpu_re_i,
  input  logic [HRO_ADDR_W-1:0] cpu_addr_i,
  input  logic [CELL_W-1:0]     cpu_wdata_i,
  output logic [CELL_W-1:0]     cpu_rdata_o,
  input  logic                  en_we_i,
  input  logic                  en_wdata_i,
  output logic                  en_o,
  input  logic                  vid_req_i,
  input  logic [HRO_ROW_W-1:0]  vid_row_i,
  input  logic [HRO_COL_W-1:0]  vid_col_i,
  input  logic [HRO_LINE_W-1:0] vid_line_i,
  input  logic [CELL_W-1:0]     vid_text_i,
  output logic [CELL_W-1:0]     vid_dots_o,
  output logic                  vid_dot_o
);
  logic [HRO_LINE_W-1:0] cpu_line, vid_line;
  logic [HRO_IDX_W-1:0]  cpu_idx, vid_idx;
  logic                  cpu_ok, vid_ok;
  logic [HRO_ADDR_W-1:0] vid_addr;

  logic [CELL_W-1:0] bank_cpu_q [LINES];
  logic [CELL_W-1:0] bank_vid_q [LINES];

  logic [HRO_LINE_W-1:0] cpu_sel_q, vid_sel_q;
  logic                  cpu_ok_q, vid_ok_q, vid_vld_q;
  logic [CELL_W-1:0]     text_q, cpu_mux, vid_mux;

  assign vid_addr = HRO_ADDR_W'({vid_line_i, vid_row_i, vid_col_i});

  hro_addr_dec #(.LINES(LINES)) u_cpu_dec (
    .addr_i (cpu_addr_i),
    .line_o (cpu_line),
    .idx_o  (cpu_idx),
    .valid_o(cpu_ok)
  );

  hro_addr_dec #(.LINES(LINES)) u_vid_dec (
    .addr_i (vid_addr),
    .line_o (vid_line),
    .idx_o  (vid_idx),
    .valid_o(vid_ok)
  );

  // one bank per raster line; invalid lines select no bank
  for (genvar g = 0; g < LINES; g++) begin : g_bank
    logic hit_cpu, hit_vid;
    assign hit_cpu = cpu_ok && (cpu_line == HRO_LINE_W'(g));
    assign hit_vid = vid_ok && (vid_line == HRO_LINE_W'(g));

    hro_bank #(.CELL_W(CELL_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (cpu_we_i && hit_cpu),
      .cpu_idx_i(cpu_idx),
      .wdata_i  (cpu_wdata_i),
      .cpu_re_i (cpu_re_i && hit_cpu),
      .cpu_q_o  (bank_cpu_q[g]),
      .vid_re_i (vid_req_i && hit_vid),
      .vid_idx_i(vid_idx),
      .vid_q_o  (bank_vid_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_sel_q <= '0;
      cpu_ok_q  <= 1'b0;
      vid_sel_q <= '0;
      vid_ok_q  <= 1'b0;
      vid_vld_q <= 1'b0;
      text_q    <= '0;
      en_o      <= 1'b0;
    end else begin
      if (cpu_re_i) begin
        cpu_sel_q <= cpu_line;
        cpu_ok_q  <= cpu_ok;
      end
      if (vid_req_i) begin
        vid_sel_q <= vid_line;
        vid_ok_q  <= vid_ok;
        text_q    <= vid_text_i;
      end
      vid_vld_q <= vid_req_i;
      if (en_we_i) en_o <= en_wdata_i;
    end
  end

  always_comb begin
    cpu_mux = '0;
    vid_mux = '0;
    for (int i = 0; i < LINES; i++) begin
      if (cpu_ok_q && cpu_sel_q == HRO_LINE_W'(i)) cpu_mux = bank_cpu_q[i];
      if (vid_ok_q && vid_sel_q == HRO_LINE_W'(i)) vid_mux = bank_vid_q[i];
    end
  end

  assign cpu_rdata_o = cpu_mux;
  assign vid_dots_o  = en_o ? (vid_mux | text_q) : text_q;

  hro_shift #(.CELL_W(CELL_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(vid_vld_q),
    .data_i(vid_dots_o),
    .dot_o (vid_dot_o)
  );
endmodule

// File: rtl/hro_checker.sv
module hro_checker
  import hro_pkg::*;
#(
  parameter int unsigned CELL_W = 6,
  parameter int unsigned LINES  = 12
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cpu_we_i,
  input logic                  cpu_re_i,
  input logic [HRO_ADDR_W-1:0] cpu_addr_i,
  input logic [CELL_W-1:0]     cpu_wdata_i,
  input logic [CELL_W-1:0]     cpu_rdata_o,
  input logic                  en_we_i,
  input logic                  en_wdata_i,
  input logic                  en_o,
  input logic                  vid_req_i,
  input logic [HRO_ROW_W-1:0]  vid_row_i,
  input logic [HRO_COL_W-1:0]  vid_col_i,
  input logic [HRO_LINE_W-1:0] vid_line_i,
  input logic [CELL_W-1:0]     vid_text_i,
  input logic [CELL_W-1:0]     vid_dots_o,
  input logic                  vid_dot_o
);
  logic unused_in;
  assign unused_in = cpu_we_i ^ (^cpu_wdata_i) ^ (^vid_row_i) ^ (^vid_col_i);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_outs_r9: assert (cpu_rdata_o == '0 && vid_dots_o == '0 && !vid_dot_o && !en_o);
    end
  end

  p_en_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> (en_o == $past(en_wdata_i)));

  p_en_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(en_o));

  p_rdata_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_re_i |=> $stable(cpu_rdata_o));

  p_bad_line_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_re_i && (32'(cpu_addr_i[HRO_USED_W-1:HRO_IDX_W]) >= LINES)) |=> (cpu_rdata_o == '0));

  p_text_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_req_i |=> ((vid_dots_o & $past(vid_text_i)) == $past(vid_text_i)));

  p_off_text_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_req_i |=> (en_o || (vid_dots_o == $past(vid_text_i))));

  p_bad_vline_text_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vid_req_i && (32'(vid_line_i) >= LINES)) |=> (vid_dots_o == $past(vid_text_i)));

  p_first_dot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_req_i |=> ##1 (vid_dot_o == $past(vid_dots_o[0])));
endmodule

bind hires_overlay hro_checker #(.CELL_W(CELL_W), .LINES(LINES)) u_hro_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_we_i   (cpu_we_i),
  .cpu_re_i   (cpu_re_i),
  .cpu_addr_i (cpu_addr_i),
  .cpu_wdata_i(cpu_wdata_i),
  .cpu_rdata_o(cpu_rdata_o),
  .en_we_i    (en_we_i),
  .en_wdata_i (en_wdata_i),
  .en_o       (en_o),
  .vid_req_i  (vid_req_i),
  .vid_row_i  (vid_row_i),
  .vid_col_i  (vid_col_i),
  .vid_line_i (vid_line_i),
  .vid_text_i (vid_text_i),
  .vid_dots_o (vid_dots_o),
  .vid_dot_o  (vid_dot_o)
);

// File: tb/hires_overlay_bench.sv
module hires_overlay_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_we_i = 1'b0, cpu_re_i = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [5:0]  cpu_wdata_i = '0;
  logic [5:0]  cpu_rdata_o;
  logic        en_we_i = 1'b0, en_wdata_i = 1'b0, en_o;
  logic        vid_req_i = 1'b0;
  logic [3:0]  vid_row_i = '0, vid_line_i = '0;
  logic [5:0]  vid_col_i = '0, vid_text_i = '0;
  logic [5:0]  vid_dots_o;
  logic        vid_dot_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hires_overlay u_hires_overlay (.*);

  function automatic logic [15:0] mk(input logic [1:0] hi, input logic [3:0] line,
                                     input logic [3:0] row, input logic [5:0] col);
    return {hi, line, row, col};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [5:0] d);
    @(negedge clk_i);
    cpu_we_i = 1; cpu_addr_i = a; cpu_wdata_i = d;
    @(negedge clk_i);
    cpu_we_i = 0;
  endtask

  task automatic cpu_read(input logic [15:0] a, output logic [5:0] d);
    @(negedge clk_i);
    cpu_re_i = 1; cpu_addr_i = a;
    @(negedge clk_i);
    cpu_re_i = 0;
    d = cpu_rdata_o;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk_i);
    en_we_i = 1; en_wdata_i = v;
    @(negedge clk_i);
    en_we_i = 0;
  endtask

  task automatic vid_read(input logic [3:0] row, input logic [5:0] col, input logic [3:0] line,
                          input logic [5:0] text, output logic [5:0] d);
    @(negedge clk_i);
    vid_req_i = 1; vid_row_i = row; vid_col_i = col; vid_line_i = line; vid_text_i = text;
    @(negedge clk_i);
    vid_req_i = 0;
    d = vid_dots_o;
  endtask

  task automatic t_reset();
    check("R9 rdata", cpu_rdata_o, 6'd0);
    check("R9 dots", vid_dots_o, 6'd0);
    check("R9 dot", {5'd0, vid_dot_o}, 6'd0);
    check("R9 en", {5'd0, en_o}, 6'd0);
  endtask

  task automatic t_enable();
    set_en(1);
    check("R5 en on", {5'd0, en_o}, 6'd1);
    repeat (2) @(negedge clk_i);
    check("R5 en hold", {5'd0, en_o}, 6'd1);
    set_en(0);
    check("R5 en off", {5'd0, en_o}, 6'd0);
  endtask

  task automatic t_write_read();
    logic [5:0] d;
    cpu_write(mk(0, 0, 3, 10), 6'b101101);
    cpu_write(mk(0, 11, 15, 63), 6'b110011);
    cpu_write(mk(0, 5, 0, 0), 6'b000001);
    cpu_read(mk(0, 0, 3, 10), d);   check("R2 cell A", d, 6'b101101);
    cpu_read(mk(0, 11, 15, 63), d); check("R2 cell B", d, 6'b110011);
    cpu_read(mk(0, 5, 0, 0), d);    check("R2 cell C", d, 6'b000001);
    repeat (3) @(negedge clk_i);
    check("R2 rdata hold", cpu_rdata_o, 6'b000001);
  endtask

  task automatic t_layout();
    logic [5:0] d;
    cpu_write(mk(2'b11, 7, 7, 33), 6'b011110);
    cpu_read(mk(0, 7, 7, 33), d);
    check("R1 upper bits ignored", d, 6'b011110);
    set_en(1);
    vid_read(3, 10, 0, 6'd0, d);  check("R1 video A", d, 6'b101101);
    vid_read(15, 63, 11, 6'd0, d); check("R1 video B", d, 6'b110011);
    vid_read(7, 33, 7, 6'd0, d);  check("R1 video D", d, 6'b011110);
  endtask

  task automatic t_bad_line();
    logic [5:0] d;
    for (int l = 0; l < 12; l++) cpu_write(mk(0, 4'(l), 9, 20), 6'(l * 5 + 1));
    for (int l = 12; l < 16; l++) cpu_write(mk(0, 4'(l), 9, 20), 6'b111111);
    for (int l = 12; l < 16; l++) begin
      cpu_read(mk(0, 4'(l), 9, 20), d);
      check("R3 bad line reads zero", d, 6'd0);
    end
    for (int l = 0; l < 12; l++) begin
      cpu_read(mk(0, 4'(l), 9, 20), d);
      check("R3 neighbours untouched", d, 6'(l * 5 + 1));
    end
  endtask

  task automatic t_raw();
    logic [5:0] d;
    set_en(0);
    vid_text_i = 6'b111111;
    cpu_read(mk(0, 0, 3, 10), d); check("R4 raw en off", d, 6'b101101);
    set_en(1);
    cpu_read(mk(0, 0, 3, 10), d); check("R4 raw en on", d, 6'b101101);
  endtask

  task automatic t_merge();
    logic [5:0] d;
    set_en(1);
    vid_read(3, 10, 0, 6'b010010, d); check("R6 or merge", d, 6'b111111);
    vid_read(3, 10, 0, 6'b000000, d); check("R6 overlay only", d, 6'b101101);
    vid_read(13, 5, 13, 6'b000110, d); check("R6 bad video line", d, 6'b000110);
    set_en(0);
    vid_read(3, 10, 0, 6'b010010, d); check("R6 disabled text only", d, 6'b010010);
  endtask

  task automatic t_serial();
    logic [5:0] d;
    set_en(1);
    vid_read(15, 63, 11, 6'b000100, d);
    check("R7 parallel", d, 6'b110111);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      check($sformatf("R7 dot %0d", k), {5'd0, vid_dot_o}, {5'd0, d[k]});
    end
    @(negedge clk_i);
    check("R7 trailing zero", {5'd0, vid_dot_o}, 6'd0);
  endtask

  task automatic t_collide();
    logic [5:0] d;
    set_en(1);
    @(negedge clk_i);
    cpu_we_i = 1; cpu_addr_i = mk(0, 5, 0, 0); cpu_wdata_i = 6'b100000;
    vid_req_i = 1; vid_row_i = 0; vid_col_i = 0; vid_line_i = 5; vid_text_i = 6'd0;
    @(negedge clk_i);
    cpu_we_i = 0; vid_req_i = 0;
    check("R8 video sees old", vid_dots_o, 6'b000001);
    cpu_read(mk(0, 5, 0, 0), d); check("R8 write landed", d, 6'b100000);
    @(negedge clk_i);
    cpu_we_i = 1; cpu_re_i = 1; cpu_addr_i = mk(0, 0, 3, 10); cpu_wdata_i = 6'b000111;
    @(negedge clk_i);
    cpu_we_i = 0; cpu_re_i = 0;
    check("R8 cpu read old", cpu_rdata_o, 6'b101101);
    cpu_read(mk(0, 0, 3, 10), d); check("R8 cpu new", d, 6'b000111);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    t_enable();
    t_write_read();
    t_layout();
    t_bad_line();
    t_raw();
    t_merge();
    t_serial();
    t_collide();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule